// File: doc/BRIEF.md
# Serial Stereo Volume Control Port

This block is the control-port logic of a stereo volume controller. It runs on a fast system clock and oversamples four slow pins: a serial bit clock, an active-low frame select, an active-low mute request and a serial data input. Each pin passes through a two-flop synchronizer, and edges are found from the synchronized levels.

While the frame select is low, each rising serial-clock edge shifts one data bit into a 16-bit shift register. Each falling edge moves the top bit of that register to the serial data output, so several devices can be daisy-chained. The rising edge of the frame select copies the register into the two 8-bit channel gain codes. Each code is decoded into a signed gain in half-dB steps and a per-channel mute flag. A mute timer measures how long the mute request has been held and raises a calibration-done flag once a 2 ms window has passed. Only an output enable is produced for the serial output pad.

The framing state machine has two states:
- `ST_IDLE`: the frame select is high and the output enable is off.
- `ST_FRAME`: a frame is open.

It has two transitions:
- open (`ST_IDLE` to `ST_FRAME` on a frame-select fall): the output is loaded with the top held bit.
- commit (`ST_FRAME` to `ST_IDLE` on a frame-select rise): the word is latched.

Top module: `svol_ctrl`

## Requirements
- R1: After reset:
  - both gain codes are 0 and both channel mute flags are 1;
  - the output enable, the serial data output and the calibration-done flag are 0;
  - the shift register holds zero.
- R2: While the frame is open, data is sampled on serial-clock rising edges, most significant bit first. Of a 16-bit frame, the first byte becomes the right code and the second byte the left code.
- R3: The serial output takes bit 15 of the shift register when a frame opens and after each serial-clock falling edge. Over a 16-bit frame it therefore presents the 16 bits held before the frame, first bit first.
- R4: The output enable is 1 only while a frame is open. It returns to 0 once the frame select is high.
- R5: The gain codes change only on a frame-select rise, on the third clock edge after the pin changes. Serial-clock edges while the frame select is high change neither the codes nor the shift register.
- R6: When more than 16 bits are clocked in one frame, the last 16 bits are the ones latched.
- R7: Each signed gain output equals the code minus 192, in 0.5 dB units: code 255 gives +63 (+31.5 dB), code 192 gives 0, and code 1 gives -191 (-95.5 dB). Code 0 sets that channel's mute flag.
- R8: A low mute request sets both mute flags on the second clock edge after the pin falls, whatever the codes are. The codes themselves are left unchanged.
- R9: With `CAL_CYC = CLK_HZ/1000*CAL_MS`, the calibration-done flag:
  - rises on clock edge `CAL_CYC+2` after the mute request falls and stays held, and is 0 one edge earlier;
  - is 0 on the second edge after release;
  - never rises for a shorter mute.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk_i | input | 1 | Serial bit clock (asynchronous) |
| cs_n_i | input | 1 | Active-low frame select |
| mute_n_i | input | 1 | Active-low mute request |
| sdin_i | input | 1 | Serial data input |
| sdout_o | output | 1 | Serial data output for daisy-chaining |
| sdout_oe_o | output | 1 | Output enable for the serial output pad |
| gain_r_code_o | output | 8 | Latched right channel code |
| gain_l_code_o | output | 8 | Latched left channel code |
| gain_r_db2_o | output | 9 | Right gain, signed, half-dB units |
| gain_l_db2_o | output | 9 | Left gain, signed, half-dB units |
| mute_r_o | output | 1 | Right channel muted |
| mute_l_o | output | 1 | Left channel muted |
| cal_done_o | output | 1 | Mute window long enough for calibration |

## Verification
Every pin goes through two synchronizer flops and one edge-history flop. As a result:
- a gain commit appears on the third clock edge after the frame-select pin rises;
- the mute flags follow the second edge after the mute pin falls;
- the calibration flag rises on edge `CAL_CYC+2`.

The bench drives pins just after a falling clock edge. For the commit, mute and calibration checks it counts rising edges exactly and samples one nanosecond after the edge where the change is due, and also the edge before it, so the checks catch an early result as well as a late one. For the serial output, each serial-clock half period lasts four system clocks, and the bench samples the output just before raising the serial clock, as a downstream device would.

// File: rtl/svol_pkg.sv
package svol_pkg;
    localparam int CODE_W     = 8;
    localparam int FRAME_W    = 2 * CODE_W;
    localparam int DB2_W      = CODE_W + 1;
    localparam int UNITY_CODE = 192;

    typedef enum logic {
        ST_IDLE,
        ST_FRAME
    } svol_state_e;

    function automatic logic signed [DB2_W-1:0] code_to_db2(input logic [CODE_W-1:0] code);
        return $signed({1'b0, code}) - DB2_W'(UNITY_CODE);
    endfunction
endpackage

// File: rtl/svol_sync.sv
module svol_sync #(
    parameter int             W   = 4,
    parameter logic [W-1:0]   RST = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] lvl_o,
    output logic [W-1:0] rise_o,
    output logic [W-1:0] fall_o
);
    logic [W-1:0] s1_q, s2_q, s3_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_q <= RST;
            s2_q <= RST;
            s3_q <= RST;
        end else begin
            s1_q <= d_i;
            s2_q <= s1_q;
            s3_q <= s2_q;
        end
    end

    assign lvl_o  = s2_q;
    assign rise_o = s2_q & ~s3_q;
    assign fall_o = ~s2_q & s3_q;
endmodule

// File: rtl/svol_frame.sv
module svol_frame
    import svol_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sclk_rise_i,
    input  logic               sclk_fall_i,
    input  logic               cs_lvl_i,
    input  logic               cs_rise_i,
    input  logic               cs_fall_i,
    input  logic               sdin_i,
    output logic [FRAME_W-1:0] word_o,
    output logic               sdout_o,
    output logic               oe_o
);
    svol_state_e        state_q, state_d;
    logic [FRAME_W-1:0] sreg_q;
    logic [FRAME_W-1:0] word_q;
    logic               sdout_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (cs_fall_i) state_d = ST_FRAME;
            ST_FRAME: if (cs_rise_i) state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sreg_q  <= '0;
            word_q  <= '0;
            sdout_q <= 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (cs_fall_i) sdout_q <= sreg_q[FRAME_W-1];
                end
                ST_FRAME: begin
                    if (cs_rise_i)        word_q  <= sreg_q;
                    else if (sclk_rise_i) sreg_q  <= {sreg_q[FRAME_W-2:0], sdin_i};
                    else if (sclk_fall_i) sdout_q <= sreg_q[FRAME_W-1];
                end
            endcase
        end
    end

    always_comb begin
        oe_o    = (state_q == ST_FRAME);
        word_o  = word_q;
        sdout_o = sdout_q;
    end

    p_oe_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
        cs_lvl_i |=> !oe_o);
    p_word_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_rise_i |=> $stable(word_q));
    p_sdout_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(sclk_fall_i || cs_fall_i) |=> $stable(sdout_q));
endmodule

// File: rtl/svol_caltimer.sv
module svol_caltimer #(
    parameter int CAL_CYC = 200_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic muted_i,
    output logic cal_done_o
);
    localparam int CNT_W = $clog2(CAL_CYC + 1);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                          cnt_q <= '0;
        else if (!muted_i)                   cnt_q <= '0;
        else if (cnt_q != CNT_W'(CAL_CYC))   cnt_q <= cnt_q + 1'b1;
    end

    assign cal_done_o = muted_i && (cnt_q == CNT_W'(CAL_CYC));

    p_done_after_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cal_done_o) |-> $past(muted_i));
endmodule

// File: rtl/svol_ctrl.sv
module svol_ctrl
    import svol_pkg::*;
#(
    parameter int CLK_HZ = 100_000_000,
    parameter int CAL_MS = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     sclk_i,
    input  logic                     cs_n_i,
    input  logic                     mute_n_i,
    input  logic                     sdin_i,
    output logic                     sdout_o,
    output logic                     sdout_oe_o,
    output logic [7:0]               gain_r_code_o,
    output logic [7:0]               gain_l_code_o,
    output logic signed [8:0]        gain_r_db2_o,
    output logic signed [8:0]        gain_l_db2_o,
    output logic                     mute_r_o,
    output logic                     mute_l_o,
    output logic                     cal_done_o
);
    localparam int CAL_CYC = CLK_HZ / 1000 * CAL_MS;
    localparam int NPIN    = 4;
    localparam int P_SCLK  = 0;
    localparam int P_CS    = 1;
    localparam int P_MUTE  = 2;
    localparam int P_SDIN  = 3;
    localparam logic [NPIN-1:0] PIN_RST = 4'b0110;

    logic [NPIN-1:0]    pin_lvl, pin_rise, pin_fall;
    logic [FRAME_W-1:0] word;
    logic               mute_act;
    logic [CODE_W-1:0]  code   [2];
    logic signed [DB2_W-1:0] db2 [2];
    logic [1:0]         ch_mute;

    svol_sync #(.W(NPIN), .RST(PIN_RST)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .d_i    ({sdin_i, mute_n_i, cs_n_i, sclk_i}),
        .lvl_o  (pin_lvl),
        .rise_o (pin_rise),
        .fall_o (pin_fall)
    );

    svol_frame u_frame (
        .clk         (clk),
        .rst_n       (rst_n),
        .sclk_rise_i (pin_rise[P_SCLK]),
        .sclk_fall_i (pin_fall[P_SCLK]),
        .cs_lvl_i    (pin_lvl[P_CS]),
        .cs_rise_i   (pin_rise[P_CS]),
        .cs_fall_i   (pin_fall[P_CS]),
        .sdin_i      (pin_lvl[P_SDIN]),
        .word_o      (word),
        .sdout_o     (sdout_o),
        .oe_o        (sdout_oe_o)
    );

    assign mute_act = !pin_lvl[P_MUTE];

    svol_caltimer #(.CAL_CYC(CAL_CYC)) u_cal (
        .clk        (clk),
        .rst_n      (rst_n),
        .muted_i    (mute_act),
        .cal_done_o (cal_done_o)
    );

    // channel 0 = right (first byte), channel 1 = left (second byte)
    assign code[0] = word[FRAME_W-1 -: CODE_W];
    assign code[1] = word[CODE_W-1:0];

    for (genvar ch = 0; ch < 2; ch++) begin : g_chan
        assign db2[ch]     = code_to_db2(code[ch]);
        assign ch_mute[ch] = mute_act || (code[ch] == '0);
    end

    assign gain_r_code_o = code[0];
    assign gain_l_code_o = code[1];
    assign gain_r_db2_o  = db2[0];
    assign gain_l_db2_o  = db2[1];
    assign mute_r_o      = ch_mute[0];
    assign mute_l_o      = ch_mute[1];

    p_mute_both_r8: assert property (@(posedge clk) disable iff (!rst_n)
        mute_act |-> (mute_l_o && mute_r_o));
    p_unity_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (gain_l_code_o == 8'd192) |-> (gain_l_db2_o == 9'sd0));
    p_zero_code_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (gain_r_code_o == 8'd0) |-> mute_r_o);
endmodule

// File: tb/test_svol_ctrl.sv
module test_svol_ctrl;
    localparam int CLK_HZ  = 10_000;
    localparam int CAL_MS  = 2;
    localparam int CAL_CYC = CLK_HZ / 1000 * CAL_MS;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sclk = 1'b0, cs_n = 1'b1, mute_n = 1'b1, sdin = 1'b0;
    logic sdout, oe, mute_r, mute_l, cal_done;
    logic [7:0] code_r, code_l;
    logic signed [8:0] db2_r, db2_l;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    svol_ctrl #(.CLK_HZ(CLK_HZ), .CAL_MS(CAL_MS)) i_svol_ctrl (
        .clk(clk), .rst_n(rst_n), .sclk_i(sclk), .cs_n_i(cs_n),
        .mute_n_i(mute_n), .sdin_i(sdin), .sdout_o(sdout), .sdout_oe_o(oe),
        .gain_r_code_o(code_r), .gain_l_code_o(code_l),
        .gain_r_db2_o(db2_r), .gain_l_db2_o(db2_l),
        .mute_r_o(mute_r), .mute_l_o(mute_l), .cal_done_o(cal_done)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic edges(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic open_frame();
        @(negedge clk) cs_n = 1'b0;
        edges(4);
    endtask

    // shift n bits MSB first; sample sdout just before each rising sclk
    task automatic shift_bits(input logic [31:0] data, input int n, output logic [31:0] seen);
        seen = '0;
        for (int i = 0; i < n; i++) begin
            seen = {seen[30:0], sdout};
            @(negedge clk) sdin = data[n-1-i];
            edges(4);
            @(negedge clk) sclk = 1'b1;
            edges(4);
            @(negedge clk) sclk = 1'b0;
            edges(4);
        end
    endtask

    // close frame and check commit latency (R5)
    task automatic close_frame(input logic [7:0] old_r, input logic [7:0] new_r,
                               input logic [7:0] new_l);
        @(negedge clk) cs_n = 1'b1;
        edges(2);
        chk(code_r == old_r, "R5 commit not early", code_r, old_r);
        edges(1);
        chk(code_r == new_r, "R5 commit on 3rd edge (R2 right byte)", code_r, new_r);
        chk(code_l == new_l, "R2 left byte", code_l, new_l);
        edges(2);
        chk(oe == 1'b0, "R4 oe off after frame", oe, 0);
    endtask

    task automatic t_reset();
        chk(code_r == 0 && code_l == 0, "R1 codes zero", {code_r, code_l}, 0);
        chk(mute_r && mute_l, "R1 mute flags", {mute_r, mute_l}, 3);
        chk(!oe && !sdout && !cal_done, "R1 oe/sdout/cal", {oe, sdout, cal_done}, 0);
    endtask

    task automatic t_frame_extremes();
        logic [31:0] seen;
        open_frame();
        chk(oe == 1'b1, "R4 oe on in frame", oe, 1);
        shift_bits(32'hFF01, 16, seen);
        chk(seen[15:0] == 16'h0000, "R3 cleared register out after reset", seen[15:0], 0);
        close_frame(8'h00, 8'hFF, 8'h01);
        chk(db2_r == 63, "R7 code 255 -> +63", db2_r, 63);
        chk(db2_l == -191, "R7 code 1 -> -191", db2_l, -191);
        chk(!mute_r && !mute_l, "R7 nonzero codes unmuted", {mute_r, mute_l}, 0);
    endtask

    task automatic t_frame_daisy();
        logic [31:0] seen;
        open_frame();
        shift_bits(32'h00C0, 16, seen);
        chk(seen[15:0] == 16'hFF01, "R3 previous word out", seen[15:0], 16'hFF01);
        close_frame(8'hFF, 8'h00, 8'hC0);
        chk(mute_r == 1'b1, "R7 code 0 mutes right", mute_r, 1);
        chk(db2_l == 0, "R7 code 192 -> 0", db2_l, 0);
    endtask

    task automatic t_ignored_sclk();
        logic [31:0] seen;
        sdin = 1'b1;
        for (int i = 0; i < 5; i++) begin
            @(negedge clk) sclk = 1'b1;
            edges(4);
            @(negedge clk) sclk = 1'b0;
            edges(4);
        end
        chk(code_r == 8'h00 && code_l == 8'hC0, "R5 sclk with cs high ignored",
            {code_r, code_l}, 16'h00C0);
        open_frame();
        shift_bits(32'h8040, 16, seen);
        chk(seen[15:0] == 16'h00C0, "R5 shift register untouched by idle sclk",
            seen[15:0], 16'h00C0);
        close_frame(8'h00, 8'h80, 8'h40);
        chk(db2_r == -64 && db2_l == -128, "R7 mid codes", db2_r, -64);
    endtask

    task automatic t_long_frame();
        logic [31:0] seen;
        open_frame();
        shift_bits(32'hAB1234, 24, seen);
        chk(seen[23:8] == 16'h8040, "R3 first 16 out of long frame", seen[23:8], 16'h8040);
        close_frame(8'h80, 8'h12, 8'h34);
        chk(code_l == 8'h34, "R6 last 16 bits latched", code_l, 8'h34);
    endtask

    task automatic t_mute_cal();
        @(negedge clk) mute_n = 1'b0;
        edges(1);
        chk(!mute_r && !mute_l, "R8 mute not before 2nd edge", {mute_r, mute_l}, 0);
        edges(1);
        chk(mute_r && mute_l, "R8 both muted", {mute_r, mute_l}, 3);
        chk(code_r == 8'h12 && code_l == 8'h34, "R8 codes kept", {code_r, code_l}, 16'h1234);
        edges(CAL_CYC - 1);
        chk(cal_done == 1'b0, "R9 cal not early", cal_done, 0);
        edges(1);
        chk(cal_done == 1'b1, "R9 cal on edge CAL_CYC+2", cal_done, 1);
        edges(10);
        chk(cal_done == 1'b1, "R9 cal held", cal_done, 1);
        @(negedge clk) mute_n = 1'b1;
        edges(2);
        chk(cal_done == 1'b0, "R9 cal off after release", cal_done, 0);
        chk(!mute_r && !mute_l, "R8 mute released", {mute_r, mute_l}, 0);
        // short mute never completes
        @(negedge clk) mute_n = 1'b0;
        edges(CAL_CYC / 2);
        @(negedge clk) mute_n = 1'b1;
        for (int i = 0; i < 4; i++) begin
            edges(1);
            chk(cal_done == 1'b0, "R9 short mute no cal", cal_done, 0);
        end
    endtask

    initial begin
        edges(3);
        @(negedge clk) rst_n = 1'b1;
        edges(2);
        t_reset();
        t_frame_extremes();
        t_frame_daisy();
        t_ignored_sclk();
        t_long_frame();
        t_mute_cal();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100_000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule